// File: doc/BRIEF.md
# Line Period Smoothing Filter

This block keeps a running estimate of the mains line period, counted in sample slots. Period measurements arrive on a valid strobe with a phase tag. Each one comes from a zero crossing on one of three voltage phases. All three phases feed one shared first-order recursive filter, so with all phases live the estimate is updated three times per line cycle. The gain of the filter is a signed coefficient set by the host. The estimate is held internally as a 16.16 fixed-point value.

The host can load the estimate directly. This keeps a usable period when all voltages are lost and no measurements come in. The integer part of the estimate sets the spacing of a line-cycle trigger pulse, which downstream processing uses to start its work. The block also outputs the line period, which is the integer estimate multiplied by a host-supplied slot period.

Top module: `line_period_filter`

## Requirements
- R1: A measurement X that is accepted updates the 16.16 estimate Y to Y + ((coef × (X·65536 − Y)) >>> 16), where >>> is an arithmetic shift that rounds toward minus infinity. The new value appears on `estimate_o` one clock after the strobe. `estimate_o` is bits [31:16] of Y.
- R2: `coef_i` is a two's-complement value with gain coef/65536. A coefficient of zero leaves Y unchanged. A negative coefficient moves Y away from X. The updated Y saturates to 0 below and to 0xFFFF_FFFF above.
- R3: Phase tags 0, 1 and 2 (phases A, B, C) are all accepted by the one shared filter. A strobe with tag 3 is ignored.
- R4: When `host_wr_i` is high, Y becomes `host_period_i`·65536 on the next clock. This takes priority over a measurement strobe in the same cycle.
- R5: `line_period_o` equals `estimate_o` × `slot_period_i` and is registered, so it follows a change of the estimate one clock later.
- R6: The trigger counter counts `slot_tick_i` pulses. On the tick where the count reaches max(`estimate_o`, 1), the counter clears and `cycle_trig_o` is high for exactly one clock on the next cycle.
- R7: After reset, Y = RESET_EST·65536, `cycle_trig_o` = 0, `line_period_o` = 0, and the trigger counter is 0.
- R8: With neither a host write nor a measurement strobe, Y holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_valid_i | input | 1 | Period measurement strobe |
| meas_phase_i | input | 2 | Phase tag of the measurement (0=A, 1=B, 2=C, 3=invalid) |
| meas_period_i | input | 16 | Measured period in sample slots |
| coef_i | input | 16 | Signed filter coefficient |
| host_wr_i | input | 1 | Host load of the estimate |
| host_period_i | input | 16 | Integer period loaded by the host |
| slot_period_i | input | 16 | Slot period calibration value |
| slot_tick_i | input | 1 | One pulse per sample slot |
| estimate_o | output | 16 | Integer part of the global estimate |
| line_period_o | output | 32 | Estimate times slot period |
| cycle_trig_o | output | 1 | Line-cycle trigger pulse |

## Verification
A wrong estimate register shows up on `estimate_o` one clock after the update that corrupts it. The same error reaches `line_period_o` a clock later and changes the trigger spacing within one trigger interval. Errors in the fraction stay hidden until a later update carries them across the integer boundary. For this reason the stimulus includes cases that floor just below a whole slot, such as a quarter-slot step down, and also a sequence of interleaved phase updates compared against a model of the full 16.16 value. Saturation and the host-write priority are checked in the single cycle where they decide the result.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  typedef enum logic [1:0] {
    PH_A    = 2'd0,
    PH_B    = 2'd1,
    PH_C    = 2'd2,
    PH_NONE = 2'd3
  } phase_e;
endpackage

// File: rtl/lpf_update.sv
module lpf_update #(
  parameter int EST_W  = 16,
  parameter int FRAC_W = 16,
  parameter int COEF_W = 16
) (
  input  logic [EST_W+FRAC_W-1:0] y_i,
  input  logic [EST_W-1:0]        x_i,
  input  logic [COEF_W-1:0]       coef_i,
  output logic [EST_W+FRAC_W-1:0] y_o
);
  localparam int ACC_W  = EST_W + FRAC_W;
  localparam int DIFF_W = ACC_W + 1;
  localparam int PROD_W = COEF_W + DIFF_W;

  logic signed [DIFF_W-1:0] diff;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] delta;
  logic signed [PROD_W-1:0] sum;

  always_comb begin
    diff  = $signed({1'b0, x_i, {FRAC_W{1'b0}}}) - $signed({1'b0, y_i});
    prod  = PROD_W'($signed(coef_i)) * PROD_W'(diff);
    delta = prod >>> FRAC_W;
    sum   = PROD_W'($signed({1'b0, y_i})) + delta;
    // clamp to the unsigned accumulator range
    if (sum[PROD_W-1])               y_o = '0;
    else if (|sum[PROD_W-2:ACC_W])   y_o = '1;
    else                             y_o = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/lpf_cycle_trigger.sv
module lpf_cycle_trigger #(
  parameter int EST_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [EST_W-1:0] est_i,
  output logic             trig_o
);
  logic [EST_W-1:0] cnt_q;
  logic [EST_W:0]   limit;
  logic [EST_W:0]   next_cnt;

  assign limit    = (est_i == '0) ? (EST_W+1)'(1) : {1'b0, est_i};
  assign next_cnt = {1'b0, cnt_q} + (EST_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trig_o <= 1'b0;
    end else if (tick_i) begin
      if (next_cnt >= limit) begin
        cnt_q  <= '0;
        trig_o <= 1'b1;
      end else begin
        cnt_q  <= next_cnt[EST_W-1:0];
        trig_o <= 1'b0;
      end
    end else begin
      trig_o <= 1'b0;
    end
  end

  p_trig_after_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(tick_i));

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && est_i > 1 && $stable(est_i)) |=> !trig_o);
endmodule

// File: rtl/lpf_period_scale.sv
module lpf_period_scale #(
  parameter int EST_W = 16,
  parameter int CAL_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [EST_W-1:0]       est_i,
  input  logic [CAL_W-1:0]       slot_i,
  output logic [EST_W+CAL_W-1:0] period_o
);
  localparam int LP_W = EST_W + CAL_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) period_o <= '0;
    else         period_o <= LP_W'(est_i) * LP_W'(slot_i);
  end

  p_zero_est_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (est_i == '0) |=> (period_o == '0));

  p_zero_slot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == '0) |=> (period_o == '0));
endmodule

// File: rtl/line_period_filter.sv
module line_period_filter
  import lpf_pkg::*;
#(
  parameter int EST_W     = 16,
  parameter int FRAC_W    = 16,
  parameter int COEF_W    = 16,
  parameter int CAL_W     = 16,
  parameter int RESET_EST = 1000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   meas_valid_i,
  input  logic [1:0]             meas_phase_i,
  input  logic [EST_W-1:0]       meas_period_i,
  input  logic [COEF_W-1:0]      coef_i,
  input  logic                   host_wr_i,
  input  logic [EST_W-1:0]       host_period_i,
  input  logic [CAL_W-1:0]       slot_period_i,
  input  logic                   slot_tick_i,
  output logic [EST_W-1:0]       estimate_o,
  output logic [EST_W+CAL_W-1:0] line_period_o,
  output logic                   cycle_trig_o
);
  localparam int ACC_W = EST_W + FRAC_W;

  logic [ACC_W-1:0] y_q;
  logic [ACC_W-1:0] y_upd;
  phase_e           phase;
  logic             take;

  assign phase = phase_e'(meas_phase_i);
  assign take  = meas_valid_i && (phase != PH_NONE);

  lpf_update #(
    .EST_W (EST_W),
    .FRAC_W(FRAC_W),
    .COEF_W(COEF_W)
  ) u_update (
    .y_i   (y_q),
    .x_i   (meas_period_i),
    .coef_i(coef_i),
    .y_o   (y_upd)
  );

  // host load has priority over a same-cycle measurement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        y_q <= {EST_W'(RESET_EST), {FRAC_W{1'b0}}};
    else if (host_wr_i) y_q <= {host_period_i, {FRAC_W{1'b0}}};
    else if (take)      y_q <= y_upd;
  end

  assign estimate_o = y_q[ACC_W-1:FRAC_W];

  lpf_cycle_trigger #(
    .EST_W(EST_W)
  ) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(slot_tick_i),
    .est_i (estimate_o),
    .trig_o(cycle_trig_o)
  );

  lpf_period_scale #(
    .EST_W(EST_W),
    .CAL_W(CAL_W)
  ) u_scale (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .est_i   (estimate_o),
    .slot_i  (slot_period_i),
    .period_o(line_period_o)
  );

  p_host_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> (y_q == {$past(host_period_i), {FRAC_W{1'b0}}}));

  p_tag3_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && meas_valid_i && meas_phase_i == 2'd3) |=> $stable(y_q));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && !meas_valid_i) |=> $stable(y_q));

  p_zero_gain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && take && coef_i == '0) |=> $stable(y_q));

  p_toward_target_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && take && $signed(coef_i) > 0 &&
     {meas_period_i, {FRAC_W{1'b0}}} >= y_q)
    |=> (y_q >= $past(y_q) && y_q <= {$past(meas_period_i), {FRAC_W{1'b0}}}));
endmodule

// File: tb/sim_line_period_filter.sv
`timescale 1ns/1ps
module sim_line_period_filter;
  localparam int RST_EST = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        meas_valid = 1'b0;
  logic [1:0]  meas_phase = 2'd0;
  logic [15:0] meas_period = '0;
  logic [15:0] coef = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_period = '0;
  logic [15:0] slot_period = 16'd250;
  logic        slot_tick = 1'b0;
  logic [15:0] estimate;
  logic [31:0] line_period;
  logic        cycle_trig;

  int errors = 0;
  int checks = 0;
  int wd = 0;

  always #10 clk = ~clk;

  line_period_filter #(.RESET_EST(RST_EST)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .meas_valid_i(meas_valid), .meas_phase_i(meas_phase),
    .meas_period_i(meas_period), .coef_i(coef),
    .host_wr_i(host_wr), .host_period_i(host_period),
    .slot_period_i(slot_period), .slot_tick_i(slot_tick),
    .estimate_o(estimate), .line_period_o(line_period),
    .cycle_trig_o(cycle_trig)
  );

  typedef struct packed {
    logic [15:0] pre;
    logic [1:0]  ph;
    logic [15:0] x;
    logic [15:0] cf;
    logic [15:0] exp_est;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{16'd1000,  2'd0, 16'd1040,  16'h4000, 16'd1010},  // R1 +0.25 step
    '{16'd1000,  2'd1, 16'd1040,  16'h8000, 16'd980},   // R2 negative gain
    '{16'd1000,  2'd2, 16'd900,   16'h2000, 16'd987},   // R1 floor of 987.5
    '{16'd1000,  2'd2, 16'd999,   16'h4000, 16'd999},   // R1 999.75
    '{16'd1000,  2'd3, 16'd2000,  16'h4000, 16'd1000},  // R3 tag 3 ignored
    '{16'd1000,  2'd0, 16'd2000,  16'h0000, 16'd1000},  // R2 zero gain
    '{16'd10,    2'd1, 16'd60000, 16'h7FFF, 16'd30004}, // R1 large step
    '{16'd5,     2'd0, 16'd0,     16'h8000, 16'd7},     // R2 away from X
    '{16'd10,    2'd0, 16'd100,   16'h8000, 16'd0},     // R2 low clamp
    '{16'd65000, 2'd0, 16'd0,     16'h8000, 16'd65535}, // R2 high clamp
    '{16'd1000,  2'd1, 16'd1000,  16'h7FFF, 16'd1000}   // R3 phase B, no error
  };

  task automatic chk(input string req, input longint act, input longint exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic longint model(input longint y, input int x, input int cf);
    longint d, n;
    d = (longint'(x) <<< 16) - y;
    n = y + ((longint'(cf) * d) >>> 16);
    if (n < 0) n = 0;
    if (n > 64'hFFFF_FFFF) n = 64'hFFFF_FFFF;
    return n;
  endfunction

  task automatic host_load(input logic [15:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_period = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic measure(input logic [1:0] ph, input logic [15:0] x, input logic [15:0] cf);
    @(negedge clk);
    meas_valid = 1'b1; meas_phase = ph; meas_period = x; coef = cf;
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint y_ref;
    int t_first, t_second, width;

    // R7 reset state
    #5;
    @(negedge clk);
    chk("R7 estimate", estimate, RST_EST);
    chk("R7 trigger", cycle_trig, 0);
    chk("R7 line period", line_period, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 after reset", line_period, RST_EST * 250);

    // table walk
    for (int i = 0; i < NV; i++) begin
      host_load(VEC[i].pre);
      measure(VEC[i].ph, VEC[i].x, VEC[i].cf);
      chk($sformatf("R1 vec %0d estimate", i), estimate, VEC[i].exp_est);
      @(negedge clk);
      chk($sformatf("R5 vec %0d line period", i), line_period,
          longint'(VEC[i].exp_est) * 250);
    end

    // R4 host write wins over same-cycle measurement
    host_load(16'd500);
    @(negedge clk);
    host_wr = 1'b1; host_period = 16'd1234;
    meas_valid = 1'b1; meas_phase = 2'd0; meas_period = 16'd3000; coef = 16'h7FFF;
    @(negedge clk);
    host_wr = 1'b0; meas_valid = 1'b0;
    chk("R4 priority", estimate, 1234);

    // R8 hold with no strobe, inputs wiggling
    meas_period = 16'd9; coef = 16'h4000;
    repeat (5) @(negedge clk);
    chk("R8 hold", estimate, 1234);

    // R3 interleaved phases through one filter, full 16.16 model
    host_load(16'd800);
    y_ref = longint'(800) <<< 16;
    for (int k = 0; k < 9; k++) begin
      int xv;
      xv = 800 + (k * 37) % 61;
      measure(2'(k % 3), 16'(xv), 16'h1800);
      y_ref = model(y_ref, xv, 16'h1800);
      chk($sformatf("R3 interleave step %0d", k), estimate, y_ref >>> 16);
    end

    // R5 slot period change
    @(negedge clk);
    slot_period = 16'd333;
    @(negedge clk);
    chk("R5 slot change", line_period, longint'(estimate) * 333);

    // R6 trigger spacing with estimate 5
    host_load(16'd5);
    slot_tick = 1'b1;
    t_first = -1; t_second = -1; width = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (cycle_trig) begin
        width++;
        if (t_first < 0) t_first = c;
        else if (t_second < 0) t_second = c;
      end
    end
    chk("R6 spacing est=5", t_second - t_first, 5);
    chk("R6 pulse count est=5", width, 8);

    // R6 estimate 0 acts as 1: trigger on every tick
    host_load(16'd0);
    width = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (cycle_trig) width++;
    end
    chk("R6 est=0 every tick", width, 10);

    // R6 no trigger without ticks
    slot_tick = 1'b0;
    @(negedge clk);
    width = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (cycle_trig) width++;
    end
    chk("R6 no tick no trigger", width, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule